// File: doc/BRIEF.md
# General-Purpose Register File with Zero and Link Registers

This block is the register file of a small load/store processor. It holds a set of equal-width words: 32 entries of 32 bits by default. Two read ports are combinational, so the operands of an ALU instruction are available in the same cycle their indices are presented. One write port stores a result on the rising clock edge. The destination index may equal a source index; for example, the result of r9 = r8 + r9 can go back into r9.

Entry 0 is a constant zero. Whatever is sent to it is dropped, and it always reads as zero. A second, dedicated write path serves subroutine calls. When that path is enabled, a return address is placed in the top entry (31 by default) with no index supplied. If both paths aim at the top entry in the same cycle, the link path takes precedence. There is no bypass: a read in the cycle of a write still returns the value held before that edge. A synchronous reset clears every entry.

Top module: `gpr_file`

## Requirements
- R1: While `rst` is high at a rising edge, every entry is cleared, so in the cycle after reset both read ports return 32'h00000000 for every index.
- R2: With `wr_en` high at a rising edge, `wr_data` is stored in entry `wr_idx` and can be read on either port from the next cycle onward.
- R3: Index 0 always reads as 32'h00000000 on both ports, and a write through the normal port to index 0 changes no entry.
- R4: With `link_en` high at a rising edge, `link_data` is stored in entry 31 (the highest index).
- R5: When `link_en` is high and `wr_en` is high with `wr_idx` equal to 31 at the same edge, entry 31 receives `link_data`, and `wr_data` is discarded.
- R6: When a link write and a normal write to an index other than 0 or 31 occur at the same edge, both entries are updated.
- R7: A read of an entry during the cycle in which it is being written returns the value held before that edge; the new value appears in the following cycle.
- R8: The two read ports are independent: each returns the entry selected by its own index, including when both indices are equal.
- R9: Stored words are returned bit-exact for any pattern, including all-ones and alternating bit patterns.
- R10: At an edge where both `wr_en` and `link_en` are low, no entry changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all writes take place on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 5 | Destination index of the normal write |
| wr_data | input | 32 | Data of the normal write |
| link_en | input | 1 | Link write enable; the target is always the top entry |
| link_data | input | 32 | Return address written by the link path |
| rd_a_idx | input | 5 | Index of read port A |
| rd_a_data | output | 32 | Combinational data of read port A |
| rd_b_idx | input | 5 | Index of read port B |
| rd_b_data | output | 32 | Combinational data of read port B |

## Verification
Several checks run on every cycle. Index 0 reads as zero on both ports. The normal write never sets an enable for entry 0, and it never sets one for the top entry while a link write is active. A normal write can be read back in the next cycle. Ports stay stable at edges with no write, and every port reads zero just after reset. Other behaviours appear only over a scenario, so only the bench's tasks show them: the old value returned during a write, two writes committed at the same edge, the link path's precedence seen as the final content of entry 31, and exact return of specific bit patterns.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned NUM_REGS = 32;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);
  localparam int unsigned ZERO_IDX = 0;
  localparam int unsigned LINK_IDX = NUM_REGS - 1;

  // Normal-port write-enable vector: one-hot on the index, with entry 0
  // removed and the link entry removed while the link path is active.
  function automatic logic [NUM_REGS-1:0] normal_we_vec(
    input logic             en,
    input logic [IDX_W-1:0] idx,
    input logic             link_active
  );
    logic [NUM_REGS-1:0] v;
    v = '0;
    if (en) v[idx] = 1'b1;
    v[ZERO_IDX] = 1'b0;
    if (link_active) v[LINK_IDX] = 1'b0;
    return v;
  endfunction

  function automatic logic [NUM_REGS-1:0] link_we_vec(input logic en);
    logic [NUM_REGS-1:0] v;
    v = '0;
    v[LINK_IDX] = en;
    return v;
  endfunction
endpackage

// File: rtl/gpr_write_arb.sv
module gpr_write_arb
  import gpr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                link_en,
  output logic [NUM_REGS-1:0] norm_we,
  output logic [NUM_REGS-1:0] link_we
);
  assign norm_we = normal_we_vec(wr_en, wr_idx, link_en);
  assign link_we = link_we_vec(link_en);

  // R3
  norm_no_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !norm_we[ZERO_IDX]);

  // R5
  link_wins_chk: assert property (@(posedge clk) disable iff (rst)
    link_en |-> (link_we[LINK_IDX] && !norm_we[LINK_IDX]));

  // R2
  norm_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(norm_we));

  // R6
  norm_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != IDX_W'(ZERO_IDX) && wr_idx != IDX_W'(LINK_IDX))
      |-> $countones(norm_we) == 1);
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0]            norm_we,
  input  logic [NUM_REGS-1:0]            link_we,
  input  logic [XLEN-1:0]                wr_data,
  input  logic [XLEN-1:0]                link_data,
  output logic [NUM_REGS-1:0][XLEN-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q[ZERO_IDX] <= '0;
      for (int i = 1; i < NUM_REGS; i++) begin
        if (link_we[i])      q[i] <= link_data;
        else if (norm_we[i]) q[i] <= wr_data;
      end
    end
  end

  logic any_we;
  assign any_we = |norm_we || |link_we;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_we |=> $stable(q));
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic [NUM_REGS-1:0][XLEN-1:0] q,
  input  logic [IDX_W-1:0]              idx,
  output logic [XLEN-1:0]               data
);
  assign data = q[idx];

  // R3
  always_comb begin
    if (idx == IDX_W'(ZERO_IDX)) zero_read_chk: assert (data == '0);
  end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             link_en,
  input  logic [XLEN-1:0]  link_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]  rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]  rd_b_data
);
  localparam int unsigned NUM_RD = 2;

  logic [NUM_REGS-1:0]           norm_we;
  logic [NUM_REGS-1:0]           link_we;
  logic [NUM_REGS-1:0][XLEN-1:0] q;
  logic [IDX_W-1:0]              rd_idx_v  [NUM_RD];
  logic [XLEN-1:0]               rd_data_v [NUM_RD];

  gpr_write_arb u_arb (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .link_en(link_en), .norm_we(norm_we), .link_we(link_we)
  );

  gpr_storage u_store (
    .clk(clk), .rst(rst), .norm_we(norm_we), .link_we(link_we),
    .wr_data(wr_data), .link_data(link_data), .q(q)
  );

  assign rd_idx_v[0] = rd_a_idx;
  assign rd_idx_v[1] = rd_b_idx;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    gpr_read_port u_rd (.q(q), .idx(rd_idx_v[p]), .data(rd_data_v[p]));
  end

  assign rd_a_data = rd_data_v[0];
  assign rd_b_data = rd_data_v[1];

  // Event wires for the port-level checks
  logic norm_commit;
  logic link_commit;
  assign norm_commit = wr_en && (wr_idx != IDX_W'(ZERO_IDX)) &&
                       !(link_en && wr_idx == IDX_W'(LINK_IDX));
  assign link_commit = link_en;

  logic seen_reset;
  always_ff @(posedge clk) begin
    if (rst) seen_reset <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_reset && $past(rst)) |-> (rd_a_data == '0 && rd_b_data == '0));

  // R2
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_reset && !$past(rst) && $past(norm_commit) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

  // R4
  link_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_reset && !$past(rst) && $past(link_commit) && rd_b_idx == IDX_W'(LINK_IDX))
      |-> rd_b_data == $past(link_data));

  // R10
  port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !link_en && seen_reset) |=>
      ($stable(rd_a_idx) -> $stable(rd_a_data)));
endmodule

// File: tb/gpr_file_tb_top.sv
module gpr_file_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        link_en = 1'b0;
  logic [31:0] link_data = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_file dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .link_en(link_en), .link_data(link_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, commit at the rising edge, settle after it.
  task automatic cycle(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                       input logic le, input logic [31:0] ld);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; link_en = le; link_data = ld;
    @(posedge clk);
    #1;
    if (le) model[31] = ld;
    if (we && wi != 5'd0 && !(le && wi == 5'd31)) model[wi] = wd;
    @(negedge clk);
    wr_en = 1'b0; link_en = 1'b0;
  endtask

  task automatic read_both(input logic [4:0] a, input logic [4:0] b);
    rd_a_idx = a; rd_b_idx = b;
    #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    for (int i = 0; i < 32; i++) begin
      read_both(5'(i), 5'(31 - i));
      chk("R1 port A after reset", rd_a_data, 32'h0);
      chk("R1 port B after reset", rd_b_data, 32'h0);
    end
  endtask

  task automatic t_basic_write;
    for (int i = 1; i < 32; i++) cycle(1'b1, 5'(i), 32'h1000_0000 + i * 32'h0101, 1'b0, '0);
    for (int i = 1; i < 32; i++) begin
      read_both(5'(i), 5'(i));
      chk("R2 port A readback", rd_a_data, 32'h1000_0000 + i * 32'h0101);
      chk("R8 same index on port B", rd_b_data, 32'h1000_0000 + i * 32'h0101);
    end
    read_both(5'd3, 5'd17);
    chk("R8 port A independent", rd_a_data, model[3]);
    chk("R8 port B independent", rd_b_data, model[17]);
  endtask

  task automatic t_zero;
    cycle(1'b1, 5'd0, 32'hDEAD_BEEF, 1'b0, '0);
    read_both(5'd0, 5'd0);
    chk("R3 zero on port A", rd_a_data, 32'h0);
    chk("R3 zero on port B", rd_b_data, 32'h0);
    for (int i = 1; i < 32; i++) begin
      read_both(5'(i), 5'd0);
      chk("R3 no entry touched", rd_a_data, model[i]);
    end
  endtask

  task automatic t_link;
    cycle(1'b0, 5'd0, '0, 1'b1, 32'h0040_0008);
    read_both(5'd31, 5'd30);
    chk("R4 link into top entry", rd_a_data, 32'h0040_0008);
    chk("R4 neighbour untouched", rd_b_data, model[30]);
    cycle(1'b1, 5'd31, 32'hBAD0_BAD0, 1'b1, 32'h0040_0020);
    read_both(5'd31, 5'd31);
    chk("R5 link wins at top entry", rd_a_data, 32'h0040_0020);
    cycle(1'b1, 5'd9, 32'h1234_5678, 1'b1, 32'h0040_0030);
    read_both(5'd9, 5'd31);
    chk("R6 normal write kept", rd_a_data, 32'h1234_5678);
    chk("R6 link write kept", rd_b_data, 32'h0040_0030);
  endtask

  task automatic t_old_value;
    logic [31:0] old9;
    old9 = model[9];
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'h0F0F_1111;
    rd_a_idx = 5'd9; rd_b_idx = 5'd9;
    #1;
    chk("R7 old value before edge", rd_a_data, old9);
    @(posedge clk); #1;
    model[9] = 32'h0F0F_1111;
    chk("R7 new value after edge", rd_b_data, 32'h0F0F_1111);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_patterns;
    cycle(1'b1, 5'd5, 32'hFFFF_FFFF, 1'b0, '0);
    cycle(1'b1, 5'd6, 32'hAAAA_5555, 1'b0, '0);
    cycle(1'b1, 5'd7, 32'h8000_0001, 1'b0, '0);
    read_both(5'd5, 5'd6);
    chk("R9 all ones", rd_a_data, 32'hFFFF_FFFF);
    chk("R9 alternating", rd_b_data, 32'hAAAA_5555);
    read_both(5'd7, 5'd5);
    chk("R9 edge bits", rd_a_data, 32'h8000_0001);
  endtask

  task automatic t_idle;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 5'd12; wr_data = 32'h7777_7777;
    link_en = 1'b0; link_data = 32'h6666_6666;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      read_both(5'(i), 5'd31);
      chk("R10 entry unchanged", rd_a_data, model[i]);
    end
    chk("R10 top unchanged", rd_b_data, model[31]);
  endtask

  task automatic t_self_dest;
    // r9 = r8 + r9, result returned to a source register
    logic [31:0] sum;
    read_both(5'd8, 5'd9);
    sum = rd_a_data + rd_b_data;
    chk("R8 operand A", rd_a_data, model[8]);
    chk("R8 operand B", rd_b_data, model[9]);
    cycle(1'b1, 5'd9, sum, 1'b0, '0);
    read_both(5'd9, 5'd8);
    chk("R2 destination equals source", rd_a_data, model[8] + 32'h0F0F_1111);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_basic_write();
    t_zero();
    t_link();
    t_old_value();
    t_self_dest();
    t_patterns();
    t_idle();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule